// File: doc/BRIEF.md
# Guarded Sleep Entry Controller

This block sits beside the CPU of a small 8-bit microcontroller and decides when the chip may stop its clocks. It watches byte writes to a power-control register. It puts the chip to sleep only after a two-write sequence on consecutive instructions. The first write sets an arm bit and the second sets a go bit, and each write must set exactly its own bit. Both bits clear themselves and always read back as zero. A stray single write therefore cannot freeze the chip.

While asleep, the block turns off both the RC and the crystal oscillator enables and forces the address-latch and program-store strobes low. Register writes are ignored, so every stored value stays as it was at entry. Sleep ends on a synchronous reset. It also ends on a low level at the active-low external interrupt pin, but only if a wake-enable bit in an auxiliary register is set. That bit can be written only while a map-select bit in a system-control register is 1. While the wake enable is set, a global interrupt mask output is asserted. The block runs on an always-on controller clock, separate from the core clock that the oscillator enables gate.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: A write to the power-control register (default address 0x87) with bit 1 (arm) = 1 and bit 6 (go) = 0 arms the block. If the next instruction writes that register with bit 6 = 1 and bit 1 = 0, `sleep` goes high after that write's clock edge. The other data bits do not matter, and an instruction may span several cycles, ending with `insn_done`.
- R2: `sleep` rises only on the edge of a qualifying go write made while armed. A go write without a prior arm write does nothing.
- R3: A single write that sets both bit 1 and bit 6 neither arms nor starts sleep.
- R4: Arming is cancelled when the instruction after the arming one ends without a qualifying go write, or writes the power-control register with anything else. A repeated arm write only re-arms.
- R5: Bits 1 and 6 of the power-control register always read 0, and its other bits read back as written. `rd_data` shows the register at `rd_addr` one clock later.
- R6: While `sleep` is 1, `rc_osc_en`, `xtal_osc_en`, `ale_out` and `psen_out` are 0. Otherwise both enables are 1 and the strobes follow `ale_in` and `psen_in`.
- R7: The wake enable is bit 7 of the auxiliary register (default 0x88). It changes only on a write made while bit 4 (map select) of the system-control register (default 0xB1) is 1. `irq_mask` equals the wake enable.
- R8: With the wake enable clear, `int0_n` has no effect and only reset ends sleep.
- R9: With the wake enable set, `int0_n` passes a two-flop synchronizer and must be seen low on two consecutive synchronized samples. If it is held low before edges k and k+1, `sleep` falls after edge k+3. A one-cycle low pulse does not wake the block.
- R10: Register writes during sleep are ignored. Register contents and `irq_mask` are unchanged after an interrupt wake.
- R11: Synchronous active-high `rst` clears `sleep` and all registers, including during sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | High in the last cycle of each instruction |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| int0_n | input | 1 | Active-low external wake pin |
| ale_in | input | 1 | Address-latch strobe from the core |
| psen_in | input | 1 | Program-store strobe from the core |
| sleep | output | 1 | Sleep state |
| rc_osc_en | output | 1 | RC oscillator enable |
| xtal_osc_en | output | 1 | Crystal oscillator enable |
| ale_out | output | 1 | Gated address-latch strobe |
| psen_out | output | 1 | Gated program-store strobe |
| irq_mask | output | 1 | Global interrupt mask, equal to the wake enable |

## Verification
The hardest state to reach is an interrupt wake from sleep with known register contents. It needs four steps in order: a map-select write, a wake-enable write, the map select cleared, then the arm and go writes. The stimulus performs these steps and sets a recognisable system-control value. It writes to the registers during sleep to show those writes are ignored. It first sends a one-cycle pulse on `int0_n`, which must not wake the block, and then a held low level. The wake edge is then checked one cycle before and at the exact cycle that R9 predicts.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_READY = 2'd2,
    ST_SLEEP = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic low_twice
);
  logic [STAGES-1:0] chain;
  logic              hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '1;
      hist_q <= 1'b1;
    end else begin
      chain  <= {chain[STAGES-2:0], pin_n};
      hist_q <= chain[STAGES-1];
    end
  end

  // two consecutive synchronized samples low
  assign low_twice = ~chain[STAGES-1] & ~hist_q;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_sleep_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic insn_done,
  input  logic ctl_wr,
  input  logic arm_bit,
  input  logic go_bit,
  input  logic wake_ok,
  output logic sleep_q
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (state_q == ST_SLEEP) begin
      if (wake_ok) state_d = ST_IDLE;
    end else if (ctl_wr && arm_bit && !go_bit) begin
      state_d = insn_done ? ST_READY : ST_ARMED;
    end else if (state_q == ST_READY) begin
      if (ctl_wr && go_bit && !arm_bit) state_d = ST_SLEEP;
      else if (ctl_wr || insn_done)     state_d = ST_IDLE;
    end else if (state_q == ST_ARMED) begin
      if (ctl_wr)         state_d = ST_IDLE;
      else if (insn_done) state_d = ST_READY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sleep_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sleep_q <= (state_d == ST_SLEEP);
    end
  end
endmodule

// File: rtl/pwr_regs.sv
module pwr_regs #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  PWR_ADDR = 8'h87,
  parameter logic [7:0]  SYS_ADDR = 8'hB1,
  parameter logic [7:0]  AUX_ADDR = 8'h88,
  parameter int          ARM_BIT  = 1,
  parameter int          GO_BIT   = 6,
  parameter int          MAP_BIT  = 4,
  parameter int          WAKE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_live,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wake_en
);
  localparam logic [DATA_W-1:0] KEEP_MASK =
    ~((DATA_W'(1) << ARM_BIT) | (DATA_W'(1) << GO_BIT));

  logic [DATA_W-1:0] pwr_q, sys_q, aux_view, rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q   <= '0;
      sys_q   <= '0;
      wake_en <= 1'b0;
    end else if (wr_live) begin
      if (wr_addr == ADDR_W'(PWR_ADDR)) pwr_q <= wr_data & KEEP_MASK;
      if (wr_addr == ADDR_W'(SYS_ADDR)) sys_q <= wr_data;
      if (wr_addr == ADDR_W'(AUX_ADDR) && sys_q[MAP_BIT]) wake_en <= wr_data[WAKE_BIT];
    end
  end

  always_comb begin
    aux_view           = '0;
    aux_view[WAKE_BIT] = wake_en;
    if (rd_addr == ADDR_W'(PWR_ADDR))      rd_d = pwr_q;
    else if (rd_addr == ADDR_W'(SYS_ADDR)) rd_d = sys_q;
    else if (rd_addr == ADDR_W'(AUX_ADDR)) rd_d = aux_view;
    else                                   rd_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl #(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 8,
  parameter logic [7:0]  PWR_ADDR    = 8'h87,
  parameter logic [7:0]  SYS_ADDR    = 8'hB1,
  parameter logic [7:0]  AUX_ADDR    = 8'h88,
  parameter int          ARM_BIT     = 1,
  parameter int          GO_BIT      = 6,
  parameter int          MAP_BIT     = 4,
  parameter int          WAKE_BIT    = 7,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_done,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              int0_n,
  input  logic              ale_in,
  input  logic              psen_in,
  output logic              sleep,
  output logic              rc_osc_en,
  output logic              xtal_osc_en,
  output logic              ale_out,
  output logic              psen_out,
  output logic              irq_mask
);
  logic wr_live, ctl_wr, low_twice, wake_en, sleep_q;

  assign wr_live = wr_en & ~sleep_q;
  assign ctl_wr  = wr_live & (wr_addr == ADDR_W'(PWR_ADDR));

  pwr_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin_n     (int0_n),
    .low_twice (low_twice)
  );

  pwr_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .insn_done (insn_done),
    .ctl_wr    (ctl_wr),
    .arm_bit   (wr_data[ARM_BIT]),
    .go_bit    (wr_data[GO_BIT]),
    .wake_ok   (wake_en & low_twice),
    .sleep_q   (sleep_q)
  );

  pwr_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PWR_ADDR(PWR_ADDR), .SYS_ADDR(SYS_ADDR),
    .AUX_ADDR(AUX_ADDR), .ARM_BIT(ARM_BIT), .GO_BIT(GO_BIT), .MAP_BIT(MAP_BIT),
    .WAKE_BIT(WAKE_BIT)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_live (wr_live),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wake_en (wake_en)
  );

  assign sleep       = sleep_q;
  assign rc_osc_en   = ~sleep_q;
  assign xtal_osc_en = ~sleep_q;
  assign ale_out     = ale_in & ~sleep_q;
  assign psen_out    = psen_in & ~sleep_q;
  assign irq_mask    = wake_en;
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  PWR_ADDR = 8'h87,
  parameter int          ARM_BIT  = 1,
  parameter int          GO_BIT   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              sleep,
  input logic              rc_osc_en,
  input logic              xtal_osc_en,
  input logic              ale_out,
  input logic              psen_out,
  input logic              irq_mask
);
  logic to_pwr;
  assign to_pwr = wr_en && (wr_addr == ADDR_W'(PWR_ADDR));

  AST_OSC_OFF_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (!rc_osc_en && !xtal_osc_en)); // R6
  AST_STROBES_LOW: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (!ale_out && !psen_out)); // R6
  AST_ENTRY_NEEDS_GO: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep) |-> $past(to_pwr && wr_data[GO_BIT] && !wr_data[ARM_BIT])); // R2
  AST_BOTH_BITS_NO_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (!sleep && to_pwr && wr_data[GO_BIT] && wr_data[ARM_BIT]) |=> !sleep); // R3
  AST_SELF_CLEAR_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(PWR_ADDR)) |=> (!rd_data[ARM_BIT] && !rd_data[GO_BIT])); // R5
  AST_NO_WAKE_WITHOUT_EN: assert property (@(posedge clk) disable iff (rst)
    (sleep && !irq_mask) |=> sleep); // R8
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
    sleep |=> $stable(irq_mask)); // R10
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PWR_ADDR(PWR_ADDR),
  .ARM_BIT(ARM_BIT), .GO_BIT(GO_BIT)
) u_chk (.*);

// File: tb/pwr_sleep_ctrl_bench.sv
module pwr_sleep_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PWR_A = 8'h87;
  localparam logic [7:0] SYS_A = 8'hB1;
  localparam logic [7:0] AUX_A = 8'h88;

  typedef struct packed {
    logic [7:0] d1;
    logic       gap;
    logic [7:0] a2;
    logic [7:0] d2;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h02, 1'b0, PWR_A, 8'h40, 1'b1, 4'd1},  // R1 plain sequence
    '{8'h42, 1'b0, PWR_A, 8'h40, 1'b0, 4'd3},  // R3 both bits first
    '{8'h02, 1'b1, PWR_A, 8'h40, 1'b0, 4'd4},  // R4 instruction in between
    '{8'h02, 1'b0, PWR_A, 8'h42, 1'b0, 4'd3},  // R3 both bits second
    '{8'h40, 1'b0, PWR_A, 8'h40, 1'b0, 4'd2},  // R2 go without arm
    '{8'h02, 1'b0, PWR_A, 8'h02, 1'b0, 4'd4},  // R4 re-arm only
    '{8'hBF, 1'b0, PWR_A, 8'h41, 1'b1, 4'd1},  // R1 other bits ignored
    '{8'h02, 1'b0, SYS_A, 8'h40, 1'b0, 4'd4}   // R4 other register written
  };

  logic clk = 1'b0, rst = 1'b1, insn_done = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_data;
  logic int0_n = 1'b1, ale_in = 1'b1, psen_in = 1'b1;
  logic sleep, rc_osc_en, xtal_osc_en, ale_out, psen_out, irq_mask;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_sleep_ctrl #(.PWR_ADDR(PWR_A), .SYS_ADDR(SYS_A), .AUX_ADDR(AUX_A)) u_pwr_sleep_ctrl (
    .clk(clk), .rst(rst), .insn_done(insn_done), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .int0_n(int0_n),
    .ale_in(ale_in), .psen_in(psen_in), .sleep(sleep), .rc_osc_en(rc_osc_en),
    .xtal_osc_en(xtal_osc_en), .ale_out(ale_out), .psen_out(psen_out), .irq_mask(irq_mask)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic insn(input logic w, input logic [7:0] a, input logic [7:0] d);
    wr_en = w; wr_addr = a; wr_data = d; insn_done = 1'b1;
    tick();
    wr_en = 1'b0; insn_done = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    rd_addr = a; tick(); v = rd_data;
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R11 reset state
    chk("R11 sleep", sleep, 0);
    chk("R11 irq_mask", irq_mask, 0);
    rd(PWR_A, rv); chk("R11 pwr reg", rv, 0);
    rd(SYS_A, rv); chk("R11 sys reg", rv, 0);
    rd(AUX_A, rv); chk("R11 aux reg", rv, 0);
    chk("R6 osc awake", {rc_osc_en, xtal_osc_en, ale_out, psen_out}, 4'hF);

    // table of arming sequences
    for (int i = 0; i < 8; i++) begin
      do_reset();
      insn(1'b1, PWR_A, VECS[i].d1);
      if (VECS[i].gap) insn(1'b0, 8'h00, 8'h00);
      insn(1'b1, VECS[i].a2, VECS[i].d2);
      chk($sformatf("R%0d vector %0d sleep", VECS[i].req, i), sleep, VECS[i].exp);
      if (VECS[i].exp)
        chk("R6 outputs in sleep", {rc_osc_en, xtal_osc_en, ale_out, psen_out}, 4'h0);
    end

    // R1 multi-cycle arming instruction
    do_reset();
    wr_en = 1'b1; wr_addr = PWR_A; wr_data = 8'h02; tick(); wr_en = 1'b0;
    insn(1'b0, 8'h00, 8'h00);
    insn(1'b1, PWR_A, 8'h40);
    chk("R1 multi-cycle arm", sleep, 1);

    // R5 readback of self-clearing bits
    do_reset();
    insn(1'b1, PWR_A, 8'hFF);
    chk("R3 all-ones write", sleep, 0);
    rd(PWR_A, rv); chk("R5 pwr readback", rv, 8'hBD);

    // R7 wake enable gating
    insn(1'b1, AUX_A, 8'h80);
    chk("R7 mask without map", irq_mask, 0);
    rd(AUX_A, rv); chk("R7 aux without map", rv, 8'h00);
    insn(1'b1, SYS_A, 8'h10);
    insn(1'b1, AUX_A, 8'h80);
    chk("R7 mask with map", irq_mask, 1);
    rd(AUX_A, rv); chk("R7 aux with map", rv, 8'h80);

    // R9 / R10 interrupt wake with retention
    insn(1'b1, SYS_A, 8'h21);
    insn(1'b1, PWR_A, 8'h02);
    insn(1'b1, PWR_A, 8'h40);
    chk("R9 entered", sleep, 1);
    insn(1'b1, SYS_A, 8'hFF);
    insn(1'b1, SYS_A, 8'h10);
    insn(1'b1, AUX_A, 8'h00);
    int0_n = 1'b0; tick(); int0_n = 1'b1;
    repeat (4) tick();
    chk("R9 pulse ignored", sleep, 1);
    int0_n = 1'b0;
    repeat (3) tick();
    chk("R9 not yet awake", sleep, 1);
    tick();
    chk("R9 awake", sleep, 0);
    chk("R6 osc restarted", {rc_osc_en, xtal_osc_en}, 2'b11);
    int0_n = 1'b1;
    chk("R10 mask kept", irq_mask, 1);
    rd(SYS_A, rv); chk("R10 sys kept", rv, 8'h21);

    // R8 no wake without enable
    insn(1'b1, SYS_A, 8'h10);
    insn(1'b1, AUX_A, 8'h00);
    insn(1'b1, SYS_A, 8'h00);
    chk("R7 mask cleared", irq_mask, 0);
    insn(1'b1, PWR_A, 8'h02);
    insn(1'b1, PWR_A, 8'h40);
    int0_n = 1'b0;
    repeat (10) tick();
    chk("R8 still asleep", sleep, 1);
    chk("R6 outputs in sleep", {rc_osc_en, xtal_osc_en, ale_out, psen_out}, 4'h0);
    int0_n = 1'b1;

    // R11 reset ends sleep
    do_reset();
    chk("R11 reset wakes", sleep, 0);
    chk("R11 osc on", {rc_osc_en, xtal_osc_en}, 2'b11);
    rd(SYS_A, rv); chk("R11 sys cleared", rv, 0);

    done = 1'b1;
    finish_run();
  end
endmodule